// File: doc/BRIEF.md
# Cascadable Unsigned Magnitude Comparator

This block compares two unsigned operands and raises exactly one of three result flags: greater, equal or less. It is built from identical 4-bit slices. Each slice forms per-bit greater, less and equal terms and resolves them from its most significant bit downward, so the highest bit position where the operands differ decides that slice's answer. The answer is fully combinational.

Each slice takes a three-flag tie-break input from the slice below it. The tie-break is used only when all four local bit pairs match. The top module chains `WIDTH/4` slices. The lowest slice takes its tie-break from the top-level cascade ports and the highest slice drives the result ports. An 8-bit compare is therefore two slices, with the lower slice's flags wired into the upper slice's tie-break. For a plain compare with nothing below it, tie the cascade ports to equal=1, greater=0, less=0. To build a wider comparator, feed the result flags of another instance into the cascade ports.

Top module: `mag_cmp_chain`

## Requirements
- R1: `gt_out` is 1 when, at the most significant bit position where `x_in` and `y_in` differ, `x_in` holds 1.
- R2: `lt_out` is 1 when, at the most significant bit position where `x_in` and `y_in` differ, `y_in` holds 1.
- R3: When `x_in` equals `y_in` and the cascade ports carry equal=1, greater=0, less=0, the outputs are `eq_out`=1, `gt_out`=0, `lt_out`=0.
- R4: When `x_in` equals `y_in`, each output copies its cascade input: `gt_out`=`cas_gt_in`, `eq_out`=`cas_eq_in`, `lt_out`=`cas_lt_in`. This holds for any pattern on the three cascade inputs.
- R5: When `x_in` differs from `y_in`, the cascade inputs have no effect: `eq_out` is 0 and exactly one of `gt_out`/`lt_out` is 1.
- R6: When exactly one cascade input is 1, exactly one of the three outputs is 1.
- R7: `WIDTH` is a multiple of 4 and sets the number of chained slices. With the standalone tie-off, the outputs equal the unsigned relations `x_in>y_in`, `x_in==y_in` and `x_in<y_in` over the full width, including when the upper slices tie and a lower slice decides.
- R8: The outputs follow the inputs combinationally, with no clock and no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_in | input | WIDTH | First unsigned operand |
| y_in | input | WIDTH | Second unsigned operand |
| cas_gt_in | input | 1 | Tie-break from a less significant stage: greater |
| cas_eq_in | input | 1 | Tie-break from a less significant stage: equal |
| cas_lt_in | input | 1 | Tie-break from a less significant stage: less |
| gt_out | output | 1 | x_in is greater than y_in |
| eq_out | output | 1 | x_in equals y_in, qualified by the tie-break |
| lt_out | output | 1 | x_in is less than y_in |

## Verification
The hardest case to reach is at wider widths. There, every upper slice must tie exactly, so that the decision travels down through the whole chain to the lowest slice or to the cascade ports. Uniform random operands almost never produce such ties. The 8-bit instance is swept over every operand pair. The 16-bit instance gets random pairs in which the second operand is often a copy of the first, or a copy with a single bit flipped, so that every slice position decides the result in turn. Equal operands are also paired with all eight cascade patterns to expose the pass-through, including illegal patterns.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;
    // Bits resolved by one slice.
    localparam int SLICE_BITS = 4;

    // Three-flag comparison result, also used as the tie-break link.
    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } cmp_flags_t;

    // Standalone tie-break: nothing below, so report equal.
    localparam cmp_flags_t CAS_IDLE = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};
endpackage

// File: rtl/cmp_bit_terms.sv
// Per-bit greater / less / equal terms for an N-bit pair.
module cmp_bit_terms #(
    parameter int N = 4
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    output logic [N-1:0] g,
    output logic [N-1:0] l,
    output logic [N-1:0] e
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign g[i] = a[i] & ~b[i];
        assign l[i] = ~a[i] & b[i];
        assign e[i] = ~(g[i] | l[i]);
    end
endmodule

// File: rtl/cmp_slice.sv
// One slice: priority resolution from the top bit down, tie-break from below.
module cmp_slice
    import mag_cmp_pkg::*;
#(
    parameter int N = SLICE_BITS
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  cmp_flags_t   cas_in,
    output cmp_flags_t   res
);
    logic [N-1:0] g_t;
    logic [N-1:0] l_t;
    logic [N-1:0] e_t;

    cmp_bit_terms #(.N(N)) u_terms (
        .a (a),
        .b (b),
        .g (g_t),
        .l (l_t),
        .e (e_t)
    );

    logic run_eq;
    logic loc_gt;
    logic loc_lt;

    always_comb begin
        run_eq = 1'b1;
        loc_gt = 1'b0;
        loc_lt = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            loc_gt = loc_gt | (run_eq & g_t[i]);
            loc_lt = loc_lt | (run_eq & l_t[i]);
            run_eq = run_eq & e_t[i];
        end
        res.gt = loc_gt | (run_eq & cas_in.gt);
        res.lt = loc_lt | (run_eq & cas_in.lt);
        res.eq = run_eq & cas_in.eq;
    end
endmodule

// File: rtl/mag_cmp_chain.sv
// Chain of WIDTH/SLICE_BITS slices, least significant slice first.
module mag_cmp_chain
    import mag_cmp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x_in,
    input  logic [WIDTH-1:0] y_in,
    input  logic             cas_gt_in,
    input  logic             cas_eq_in,
    input  logic             cas_lt_in,
    output logic             gt_out,
    output logic             eq_out,
    output logic             lt_out
);
    localparam int NSLICE = WIDTH / SLICE_BITS;

    cmp_flags_t link [NSLICE+1];

    assign link[0] = '{gt: cas_gt_in, eq: cas_eq_in, lt: cas_lt_in};

    for (genvar s = 0; s < NSLICE; s++) begin : g_slice
        cmp_slice #(.N(SLICE_BITS)) u_slice (
            .a      (x_in[s*SLICE_BITS +: SLICE_BITS]),
            .b      (y_in[s*SLICE_BITS +: SLICE_BITS]),
            .cas_in (link[s]),
            .res    (link[s+1])
        );
    end

    assign gt_out = link[NSLICE].gt;
    assign eq_out = link[NSLICE].eq;
    assign lt_out = link[NSLICE].lt;
endmodule

// File: rtl/mag_cmp_chain_chk.sv
module mag_cmp_chain_chk #(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0] x_in,
    input logic [WIDTH-1:0] y_in,
    input logic             cas_gt_in,
    input logic             cas_eq_in,
    input logic             cas_lt_in,
    input logic             gt_out,
    input logic             eq_out,
    input logic             lt_out
);
    logic known;
    assign known = !$isunknown({x_in, y_in, cas_gt_in, cas_eq_in, cas_lt_in,
                                gt_out, eq_out, lt_out});

    always_comb begin
        if (known) begin
            // R6
            onehot_chk: assert (($countones({cas_gt_in, cas_eq_in, cas_lt_in}) != 1)
                                || ($countones({gt_out, eq_out, lt_out}) == 1))
                else $error("outputs not one-hot for a legal tie-break");
            // R4
            tie_pass_chk: assert ((x_in != y_in)
                                  || ({gt_out, eq_out, lt_out} == {cas_gt_in, cas_eq_in, cas_lt_in}))
                else $error("tie-break not passed through on equal operands");
            // R5
            local_win_chk: assert ((x_in == y_in) || (!eq_out && (gt_out ^ lt_out)))
                else $error("local difference did not override tie-break");
            // R1
            order_gt_chk: assert ((x_in == y_in) || (gt_out == (x_in > y_in)))
                else $error("greater flag wrong");
            // R2
            order_lt_chk: assert ((x_in == y_in) || (lt_out == (x_in < y_in)))
                else $error("less flag wrong");
        end
    end
endmodule

bind mag_cmp_chain mag_cmp_chain_chk #(.WIDTH(WIDTH)) u_chk (
    .x_in      (x_in),
    .y_in      (y_in),
    .cas_gt_in (cas_gt_in),
    .cas_eq_in (cas_eq_in),
    .cas_lt_in (cas_lt_in),
    .gt_out    (gt_out),
    .eq_out    (eq_out),
    .lt_out    (lt_out)
);

// File: tb/mag_cmp_chain_test.sv
`timescale 1ns/1ps
module mag_cmp_chain_test;
    localparam int WN = 8;
    localparam int WW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic [WN-1:0] xn, yn;
    logic [WW-1:0] xw, yw;
    logic [2:0] casn, casw;          // {gt, eq, lt}
    logic gtn, eqn, ltn, gtw, eqw, ltw;

    mag_cmp_chain #(.WIDTH(WN)) uut (
        .x_in(xn), .y_in(yn),
        .cas_gt_in(casn[2]), .cas_eq_in(casn[1]), .cas_lt_in(casn[0]),
        .gt_out(gtn), .eq_out(eqn), .lt_out(ltn)
    );

    mag_cmp_chain #(.WIDTH(WW)) uut_wide (
        .x_in(xw), .y_in(yw),
        .cas_gt_in(casw[2]), .cas_eq_in(casw[1]), .cas_lt_in(casw[0]),
        .gt_out(gtw), .eq_out(eqw), .lt_out(ltw)
    );

    // Expected {gt, eq, lt} from the requirements.
    function automatic logic [2:0] expect_flags(input logic [63:0] a,
                                                input logic [63:0] b,
                                                input logic [2:0] cas);
        if (a > b)      return 3'b100;
        else if (a < b) return 3'b001;
        else            return cas;
    endfunction

    task automatic judge(input string req, input logic [2:0] act,
                         input logic [2:0] exp, input logic [63:0] a,
                         input logic [63:0] b);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s x=%0h y=%0h actual=%b expected=%b", req, a, b, act, exp);
        end
    endtask

    task automatic run_narrow(input logic [WN-1:0] a, input logic [WN-1:0] b,
                              input logic [2:0] cas, input string req);
        @(posedge clk);
        xn = a; yn = b; casn = cas;
        @(negedge clk);
        judge(req, {gtn, eqn, ltn}, expect_flags(64'(a), 64'(b), cas), 64'(a), 64'(b));
    endtask

    task automatic run_wide(input logic [WW-1:0] a, input logic [WW-1:0] b,
                            input logic [2:0] cas, input string req);
        @(posedge clk);
        xw = a; yw = b; casw = cas;
        @(negedge clk);
        judge(req, {gtw, eqw, ltw}, expect_flags(64'(a), 64'(b), cas), 64'(a), 64'(b));
    endtask

    initial begin
        xn = '0; yn = '0; casn = 3'b010;
        xw = '0; yw = '0; casw = 3'b010;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R8: first observation with idle tie-break and zero operands
        @(negedge clk);
        judge("R8", {gtn, eqn, ltn}, 3'b010, 64'd0, 64'd0);

        // Directed corners: R1, R2, R3 at the slice boundary and extremes
        run_narrow(8'h80, 8'h7F, 3'b010, "R1");
        run_narrow(8'h7F, 8'h80, 3'b010, "R2");
        run_narrow(8'h35, 8'h34, 3'b010, "R1");
        run_narrow(8'h34, 8'h35, 3'b010, "R2");
        run_narrow(8'hFF, 8'hFF, 3'b010, "R3");
        // R5: lower difference, tie-break says something else
        run_narrow(8'h01, 8'h00, 3'b001, "R5");
        run_narrow(8'h10, 8'h11, 3'b100, "R5");

        // R4: equal operands, all eight tie-break patterns
        for (int c = 0; c < 8; c++) begin
            run_narrow(8'hA5, 8'hA5, c[2:0], "R4");
            run_wide(16'h3C3C, 16'h3C3C, c[2:0], "R4");
        end

        // R7 / R1 / R2 / R3: every 8-bit operand pair, standalone tie-off
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                run_narrow(a[7:0], b[7:0], 3'b010, "R7");
            end
        end

        // R6 / R5: random pairs with random legal tie-break
        for (int k = 0; k < 2000; k++) begin
            logic [2:0] cs;
            cs = 3'b001 << ($urandom % 3);
            run_narrow(8'($urandom), 8'($urandom), cs, "R6");
        end

        // R7 wide: ties forced in upper slices so low slices decide
        for (int k = 0; k < 4000; k++) begin
            logic [WW-1:0] a, b;
            logic [2:0] cs;
            int mode;
            a = 16'($urandom);
            mode = int'($urandom % 4);
            if (mode == 0)      b = 16'($urandom);
            else if (mode == 1) b = a;
            else                b = a ^ (16'h1 << ($urandom % WW));
            cs = (k % 5 == 0) ? (3'b001 << ($urandom % 3)) : 3'b010;
            run_wide(a, b, cs, "R7");
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule